// File: doc/BRIEF.md
# Data-Bus Accumulator ALU

This block is a 16-bit arithmetic/logic unit that sits on a shared data bus as a single unit with its own accumulator. In a cycle where it is chosen as the load destination, it takes the bus value and optionally inverts it. It then combines the result with the accumulator under control of two function-select lines and a carry-in line. At the end of that cycle it latches the result into the accumulator.

The same edge updates three flag outputs: unsigned carry, zero and signed overflow. These are exported as plain feedback lines for a sequencer to sample. They are not meant to be read back over the bus.

The option lines are shared with other bus units, so the block only acts on them while its load strobe is high. In a cycle where it is chosen as the source, it presents the accumulator on its bus output. A result loaded in one cycle can therefore be driven in the next.

Top module: `bus_alu`

## Requirements
- R1: After reset the accumulator reads 16'h0000 and all three flags (carry, zero, overflow) are 0.
- R2: With load strobe high and function code 2'b00 (LOAD), the accumulator takes the conditioned bus operand, and carry and overflow are 0.
- R3: With function code 2'b01 (ADD), the accumulator takes the low 16 bits of accumulator + operand + carry-in, and the carry flag takes bit 16 of that sum.
- R4: With function ADD, inversion 1 and carry-in 1, the accumulator becomes accumulator minus bus (modulo 2^16), and the carry flag is 1 exactly when the accumulator was not below the bus value (unsigned).
- R5: For ADD, the overflow flag is 1 exactly when both addends have the same sign bit and the sum's sign bit differs from it.
- R6: Function code 2'b10 (XOR) stores accumulator XOR operand, with carry and overflow 0.
- R7: Function code 2'b11 stores accumulator AND operand when carry-in is 0 and accumulator OR operand when carry-in is 1, with carry and overflow 0.
- R8: After any load, the zero flag is 1 exactly when the newly latched accumulator equals 16'h0000.
- R9: When the load strobe is low, the accumulator and all flags hold their values whatever the bus and option lines carry.
- R10: The bus output equals the accumulator while the drive strobe is high and is 16'h0000 otherwise, so a value latched at one edge appears in the following cycle.
- R11: The inversion line replaces the bus value by its bitwise complement before every function, including LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Block is the load destination this cycle |
| drive_en | input | 1 | Block is the bus source this cycle |
| bus_in | input | W | Data bus value |
| fn_sel | input | 2 | Function select: 00 LOAD, 01 ADD, 10 XOR, 11 AND/OR |
| inv_in | input | 1 | Complement the bus operand |
| carry_in | input | 1 | Adder carry-in; AND/OR chooser for code 11 |
| bus_out | output | W | Accumulator when driving, zero otherwise |
| flag_cy | output | 1 | Unsigned carry of the last load |
| flag_z | output | 1 | Latched result is zero |
| flag_ov | output | 1 | Signed overflow of the last load |

## Verification
The bench builds the block at its default width of 16. At that width it can reach the exact wrap points: 16'hFFFF + 1 yields zero with carry, 16'h7FFF + 1 crosses into the sign bit, and 16'h8000 − 1 crosses out of it. It also covers both borrow outcomes of subtraction. A scoreboard carried from step to step checks that flags left set by an addition are cleared by a following logic operation, and that they survive cycles in which the strobe is low.

// File: rtl/bus_alu.sv
module bus_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         drive_en,
  input  logic [W-1:0] bus_in,
  input  logic [1:0]   fn_sel,
  input  logic         inv_in,
  input  logic         carry_in,
  output logic [W-1:0] bus_out,
  output logic         flag_cy,
  output logic         flag_z,
  output logic         flag_ov
);
  localparam logic [1:0] FN_LOAD = 2'b00;
  localparam logic [1:0] FN_ADD  = 2'b01;
  localparam logic [1:0] FN_XOR  = 2'b10;

  logic [W-1:0] acc, opnd, res;
  logic [W:0]   sum;
  logic         cy_nx, ov_nx;

  assign opnd = inv_in ? ~bus_in : bus_in;
  assign sum  = {1'b0, acc} + {1'b0, opnd} + {{W{1'b0}}, carry_in};

  always_comb begin
    cy_nx = 1'b0;
    ov_nx = 1'b0;
    case (fn_sel)
      FN_LOAD: res = opnd;
      FN_ADD: begin
        res   = sum[W-1:0];
        cy_nx = sum[W];
        ov_nx = (acc[W-1] == opnd[W-1]) && (sum[W-1] != acc[W-1]);
      end
      FN_XOR:  res = acc ^ opnd;
      default: res = carry_in ? (acc | opnd) : (acc & opnd);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      flag_cy <= 1'b0;
      flag_z  <= 1'b0;
      flag_ov <= 1'b0;
    end else if (load_en) begin
      acc     <= res;
      flag_cy <= cy_nx;
      flag_z  <= (res == '0);
      flag_ov <= ov_nx;
    end
  end

  assign bus_out = drive_en ? acc : '0;
endmodule

// File: rtl/bus_alu_chk.sv
module bus_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_en,
  input logic         drive_en,
  input logic [W-1:0] bus_in,
  input logic [1:0]   fn_sel,
  input logic         inv_in,
  input logic         carry_in,
  input logic [W-1:0] bus_out,
  input logic [W-1:0] acc,
  input logic         flag_cy,
  input logic         flag_z,
  input logic         flag_ov
);
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(acc) && $stable(flag_cy) && $stable(flag_z) && $stable(flag_ov));

  // R10
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> bus_out == '0);

  // R8
  zero_tracks_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> flag_z == (acc == '0));

  // R4
  subtract_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && fn_sel == 2'b01 && inv_in && carry_in
      |=> acc == $past(acc - bus_in) && flag_cy == ($past(acc) >= $past(bus_in)));

  // R6 R7
  logic_no_arith_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && fn_sel[1] |=> !flag_cy && !flag_ov);

  // R2
  load_no_arith_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && fn_sel == 2'b00 && !inv_in |=> acc == $past(bus_in) && !flag_cy && !flag_ov);
endmodule

bind bus_alu bus_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .drive_en(drive_en),
  .bus_in(bus_in), .fn_sel(fn_sel), .inv_in(inv_in), .carry_in(carry_in),
  .bus_out(bus_out), .acc(acc), .flag_cy(flag_cy), .flag_z(flag_z), .flag_ov(flag_ov)
);

// File: tb/tb_bus_alu.sv
module tb_bus_alu;
  logic        clk = 1'b0;
  logic        rst_n, load_en, drive_en, inv_in, carry_in;
  logic [15:0] bus_in, bus_out;
  logic [1:0]  fn_sel;
  logic        flag_cy, flag_z, flag_ov;

  int checks = 0, fails = 0;
  logic [15:0] m_acc;
  logic m_cy, m_z, m_ov;

  always #4 clk = ~clk;

  bus_alu #(.W(16)) dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .drive_en(drive_en),
    .bus_in(bus_in), .fn_sel(fn_sel), .inv_in(inv_in), .carry_in(carry_in),
    .bus_out(bus_out), .flag_cy(flag_cy), .flag_z(flag_z), .flag_ov(flag_ov)
  );

  task automatic check_state(string tag);
    drive_en = 1'b1;
    #1;
    checks++;
    if (bus_out !== m_acc || flag_cy !== m_cy || flag_z !== m_z || flag_ov !== m_ov) begin
      fails++;
      $display("FAIL %s: acc=%h cy=%b z=%b ov=%b, expected acc=%h cy=%b z=%b ov=%b",
               tag, bus_out, flag_cy, flag_z, flag_ov, m_acc, m_cy, m_z, m_ov);
    end
  endtask

  task automatic do_op(string tag, logic [1:0] f, logic inv, logic cin, logic [15:0] d);
    logic [15:0] b;
    logic [16:0] s;
    @(negedge clk);
    b = inv ? ~d : d;
    s = {1'b0, m_acc} + {1'b0, b} + 17'(cin);
    m_cy = 1'b0;
    m_ov = 1'b0;
    case (f)
      2'b00: m_acc = b;
      2'b01: begin
        m_cy = s[16];
        m_ov = (m_acc[15] == b[15]) && (s[15] != m_acc[15]);
        m_acc = s[15:0];
      end
      2'b10: m_acc = m_acc ^ b;
      default: m_acc = cin ? (m_acc | b) : (m_acc & b);
    endcase
    m_z = (m_acc == 16'h0000);
    fn_sel = f; inv_in = inv; carry_in = cin; bus_in = d;
    load_en = 1'b1; drive_en = 1'b0;
    @(negedge clk);
    load_en = 1'b0;
    check_state(tag);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; load_en = 1'b0; drive_en = 1'b0;
    fn_sel = 2'b01; inv_in = 1'b0; carry_in = 1'b1; bus_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_acc = 16'h0000; m_cy = 1'b0; m_z = 1'b0; m_ov = 1'b0;
    check_state("R1");
  endtask

  task automatic test_idle(string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      load_en = 1'b0;
      fn_sel = 2'(i); inv_in = i[0]; carry_in = ~i[0]; bus_in = 16'hA5A5 ^ 16'(i * 16'h1111);
      drive_en = 1'b0;
    end
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic test_quiet_bus();
    @(negedge clk);
    drive_en = 1'b0;
    #1;
    checks++;
    if (bus_out !== 16'h0000) begin
      fails++;
      $display("FAIL R10: bus_out=%h while not driving, expected 0000", bus_out);
    end
  endtask

  initial begin
    test_reset();
    test_quiet_bus();
    do_op("R2 load", 2'b00, 1'b0, 1'b0, 16'h1234);
    do_op("R11 load inverted", 2'b00, 1'b1, 1'b0, 16'h00FF);
    do_op("R2 load zero R8", 2'b00, 1'b0, 1'b1, 16'h0000);
    do_op("R2 load max", 2'b00, 1'b0, 1'b0, 16'hFFFF);
    do_op("R3 add wrap R8", 2'b01, 1'b0, 1'b0, 16'h0001);
    test_idle("R9 hold after carry");
    do_op("R7 and clears flags", 2'b11, 1'b0, 1'b0, 16'h0F0F);
    do_op("R2 load 7fff", 2'b00, 1'b0, 1'b0, 16'h7FFF);
    do_op("R5 add positive overflow", 2'b01, 1'b0, 1'b0, 16'h0001);
    do_op("R4 sub across sign R5", 2'b01, 1'b1, 1'b1, 16'h0001);
    do_op("R2 load 5", 2'b00, 1'b0, 1'b0, 16'h0005);
    do_op("R4 sub no borrow", 2'b01, 1'b1, 1'b1, 16'h0003);
    do_op("R4 sub borrow", 2'b01, 1'b1, 1'b1, 16'h0004);
    do_op("R4 sub self to zero R8", 2'b01, 1'b1, 1'b1, 16'hFFFE);
    do_op("R3 add with carry-in", 2'b01, 1'b0, 1'b1, 16'h1000);
    do_op("R5 add negative overflow pre", 2'b00, 1'b0, 1'b0, 16'h8000);
    do_op("R5 add negative overflow", 2'b01, 1'b0, 1'b0, 16'hFFFF);
    do_op("R6 xor", 2'b10, 1'b0, 1'b0, 16'hFFFF);
    do_op("R6 xor self zero R8", 2'b10, 1'b0, 1'b1, 16'h8000);
    do_op("R7 or", 2'b11, 1'b0, 1'b1, 16'h3C3C);
    do_op("R7 and", 2'b11, 1'b0, 1'b0, 16'h0FF0);
    do_op("R11 xor inverted", 2'b10, 1'b1, 1'b0, 16'h0F00);
    do_op("R11 or inverted", 2'b11, 1'b1, 1'b1, 16'hFFFE);
    test_idle("R9 hold after logic");
    test_quiet_bus();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule